// File: doc/BRIEF.md
# Complex NCO Frequency Translator

This block moves a real sample stream in frequency and delivers it as a complex I/Q pair. A 32-bit phase accumulator advances by a signed tuning word on every clock. A 16-bit phase offset is added to its upper half. The sum addresses a folded quarter-wave sine table, and the sine and cosine values multiply the incoming sample. Software-side logic sets the tuning word, the phase offset and a small control byte through single-byte writes on a simple write strobe.

An external sync pulse restarts the accumulator, so that the phase seen by the next sample equals the programmed offset. Several translators fed from the same sync then run with a known phase relationship. The restart can be armed for every pulse, or for only the first pulse after the control byte is written. Translation can be bypassed. An optional one-LSB amplitude dither, drawn from a free-running LFSR, can be added to the table values to break up their quantisation pattern.

Top module: `nco_translator`

## Requirements
- R1: While reset is asserted and right after it, out_valid, out_i and out_q are all zero, and the control byte is zero, which selects bypass.
- R2: With control bit 0 clear (bypass), out_i equals the input sample taken four clocks earlier and out_q is zero.
- R3: out_valid is in_valid delayed by exactly four clocks, and every accepted sample yields exactly one output, in order.
- R4: With control bit 0 set, the table phase is p = acc[31:16] + offset (mod 2^16). The value sin(p) is round(32767·sin(2π·(2·p[15:6]+1)/2048)), rounded half away from zero, and cos(p) = sin(p + 0x4000). The outputs are I = floor((x·cos + 2^14)/2^15) and Q = floor((−x·sin + 2^14)/2^15), saturated to 16-bit signed.
- R5: The accumulator adds the tuning word on every clock, modulo 2^32, with the word read as two's complement: 0x40000000 is +fs/4 and 0xC0000000 is −fs/4. The word's bytes are written at addresses 1 (bits 7:0) through 4 (bits 31:24).
- R6: Writes to addresses 1 to 3 only stage bytes. The accumulator keeps its old step until address 4 is written, and that write loads all 32 bits at once.
- R7: The phase offset is written at address 5 (low byte) and address 6 (high byte). It shifts the table phase by offset·360/65536 degrees, independent of the accumulator.
- R8: With control bit 2 set, every sync pulse clears the accumulator, so the sample taken on the next clock uses phase equal to the offset.
- R9: With control bit 3 set, a write of the control byte at address 0 arms a single restart. The first sync pulse after it restarts the accumulator, and later pulses are ignored until the control byte is written again with bit 3 set.
- R10: With control bits 2 and 3 both clear, sync pulses have no effect on the output phase.
- R11: With control bit 1 set, a 0 or 1 from a 16-bit maximal-length LFSR is added to each table value, clamped at +32767. Each output then stays within one LSB of the undithered result, and some outputs differ from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register byte write strobe |
| cfg_addr | input | 3 | Register byte address (0 control, 1-4 tuning word, 5-6 offset) |
| cfg_wdata | input | 8 | Register write byte |
| sync_in | input | 1 | Accumulator restart pulse |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 16 | Real input sample, signed |
| out_valid | output | 1 | Output pair qualifier |
| out_i | output | 16 | In-phase output, signed |
| out_q | output | 16 | Quadrature output, signed |

## Verification
A wrong accumulator value, a lost restart or a half-loaded tuning word appears four clocks later as an I/Q pair whose phase no longer matches the modelled carrier. A frequency error keeps growing sample after sample, while a phase error stays fixed. A wrong arm state in the one-shot sync mode shows up only at the next sync pulse, as a phase jump where none was due or a missing jump where one was due. A table or quadrant-folding slip appears at once, on the first sample whose phase lands in the affected quadrant.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int DW      = 16;            // sample and table width
  localparam int AW      = 32;            // accumulator width
  localparam int PW      = 16;            // phase offset width
  localparam int TW      = 8;             // quarter-table index bits
  localparam int LW      = TW + 2;        // table phase bits incl. quadrant
  localparam int CFG_AW  = 3;
  localparam int FTW_B   = AW / 8;        // tuning word bytes
  localparam int PRW     = 2 * DW + 1;    // product width
  localparam int LAT     = 4;

  localparam int A_CTRL  = 0;
  localparam int A_FTW0  = 1;
  localparam int A_FTWL  = A_FTW0 + FTW_B - 1;
  localparam int A_OFS0  = A_FTWL + 1;
  localparam int A_OFS1  = A_OFS0 + 1;

  localparam int CB_EN   = 0;
  localparam int CB_DITH = 1;
  localparam int CB_EVERY= 2;
  localparam int CB_ONCE = 3;

  typedef logic signed [DW-1:0] samp_t;

  localparam samp_t SMAX = samp_t'((2 ** (DW - 1)) - 1);
  localparam samp_t SMIN = samp_t'(-(2 ** (DW - 1)));
  localparam logic signed [PRW-1:0] PMAX = PRW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PRW-1:0] PMIN = PRW'(-(2 ** (DW - 1)));
  localparam logic signed [PRW-1:0] PRND = PRW'(2 ** (DW - 2));

  // x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // add a one-LSB dither, never wrapping past the positive limit
  function automatic samp_t dith_add(input samp_t v, input logic d);
    if (d && v != SMAX) return v + samp_t'(1);
    return v;
  endfunction

  // Q15 product back to a sample: add half, floor-shift, saturate
  function automatic samp_t q15_round(input logic signed [PRW-1:0] p);
    logic signed [PRW-1:0] t;
    t = (p + PRND) >>> (DW - 1);
    if (t > PMAX) return SMAX;
    if (t < PMIN) return SMIN;
    return samp_t'(t);
  endfunction
endpackage

// File: rtl/nco_phase.sv
module nco_phase
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              sync_in,
  output logic              xlate_en,
  output logic              dither_en,
  output logic [LW-1:0]     lut_ph,
  output logic              sync_take
);
  logic [AW-1:0]   acc;
  logic [AW-1:0]   ftw;
  logic [AW-9:0]   ftw_stage;
  logic [PW-1:0]   ofs;
  logic [3:0]      ctrl;
  logic            armed;
  logic [PW-1:0]   psum;
  logic            ctrl_wr;
  logic            ftw_commit;

  assign ctrl_wr    = cfg_we && cfg_addr == CFG_AW'(A_CTRL);
  assign ftw_commit = cfg_we && cfg_addr == CFG_AW'(A_FTWL);
  assign sync_take  = sync_in && (ctrl[CB_EVERY] || armed);
  assign xlate_en   = ctrl[CB_EN];
  assign dither_en  = ctrl[CB_DITH];
  assign psum       = acc[AW-1 -: PW] + ofs;
  assign lut_ph     = LW'(psum >> (PW - LW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      ftw       <= '0;
      ftw_stage <= '0;
      ofs       <= '0;
    end else if (cfg_we) begin
      if (ctrl_wr) ctrl <= cfg_wdata[3:0];
      for (int b = 0; b < FTW_B - 1; b++)
        if (cfg_addr == CFG_AW'(A_FTW0 + b)) ftw_stage[8*b +: 8] <= cfg_wdata;
      if (ftw_commit) ftw <= {cfg_wdata, ftw_stage};
      if (cfg_addr == CFG_AW'(A_OFS0)) ofs[7:0]  <= cfg_wdata;
      if (cfg_addr == CFG_AW'(A_OFS1)) ofs[15:8] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      armed <= 1'b0;
    end else begin
      acc <= sync_take ? '0 : acc + ftw;
      if (ctrl_wr)        armed <= cfg_wdata[CB_ONCE];
      else if (sync_take) armed <= 1'b0;
    end
  end

  a_r8_sync_clears_acc: assert property (@(posedge clk) disable iff (!rst_n)
    sync_take |=> acc == '0);
  a_r6_ftw_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ftw_commit |=> $stable(ftw));
  a_r9_once_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_take && !ctrl_wr) |=> !armed);
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos
  import nco_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lut_ph,
  input  logic          dither_en,
  output samp_t         sin_o,
  output samp_t         cos_o
);
  localparam int  QN     = 2 ** TW;
  localparam real TWO_PI = 6.283185307179586;
  localparam real AMP    = real'((2 ** (DW - 1)) - 1);

  samp_t       rom [QN];
  logic [15:0] lfsr;
  logic        dbit;
  logic [LW-1:0] ph [2];
  samp_t       raw [2];

  for (genvar k = 0; k < QN; k++) begin : g_rom
    assign rom[k] = samp_t'($rtoi(AMP * $sin(TWO_PI * (2.0 * k + 1.0) / (8.0 * QN)) + 0.5));
  end

  assign ph[0] = lut_ph;
  assign ph[1] = lut_ph + LW'(2 ** TW);

  for (genvar j = 0; j < 2; j++) begin : g_look
    logic [1:0]    quad;
    logic [TW-1:0] idx;
    samp_t         mag;
    assign quad   = ph[j][LW-1 -: 2];
    assign idx    = quad[0] ? ~ph[j][TW-1:0] : ph[j][TW-1:0];
    assign mag    = rom[idx];
    assign raw[j] = quad[1] ? -mag : mag;
  end

  assign dbit = dither_en && lfsr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr  <= 16'hACE1;
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      lfsr  <= lfsr_step(lfsr);
      sin_o <= dith_add(raw[0], dbit);
      cos_o <= dith_add(raw[1], dbit);
    end
  end

  a_r4_no_full_negative: assert property (@(posedge clk) disable iff (!rst_n)
    sin_o != SMIN && cos_o != SMIN);
  a_r11_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0);
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld_i,
  input  logic  byp_i,
  input  samp_t x_i,
  input  samp_t sin_i,
  input  samp_t cos_i,
  output logic  vld_o,
  output samp_t i_o,
  output samp_t q_o
);
  logic signed [PRW-1:0] pi_r, pq_r;
  samp_t x_r;
  logic  vld_r, byp_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pi_r  <= '0;
      pq_r  <= '0;
      x_r   <= '0;
      vld_r <= 1'b0;
      byp_r <= 1'b0;
      vld_o <= 1'b0;
      i_o   <= '0;
      q_o   <= '0;
    end else begin
      pi_r  <= PRW'(x_i) * PRW'(cos_i);
      pq_r  <= -(PRW'(x_i) * PRW'(sin_i));
      x_r   <= x_i;
      vld_r <= vld_i;
      byp_r <= byp_i;
      vld_o <= vld_r;
      i_o   <= byp_r ? x_r : q15_round(pi_r);
      q_o   <= byp_r ? '0  : q15_round(pq_r);
    end
  end
endmodule

// File: rtl/nco_translator.sv
module nco_translator
  import nco_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_addr,
  input  logic [7:0]               cfg_wdata,
  input  logic                     sync_in,
  input  logic                     in_valid,
  input  logic signed [15:0]       in_data,
  output logic                     out_valid,
  output logic signed [15:0]       out_i,
  output logic signed [15:0]       out_q
);
  logic          xlate_en, dither_en, sync_take;
  logic [LW-1:0] lut_ph, ph_s1;
  samp_t         x_s1, x_s2, sin_s2, cos_s2;
  logic          vld_s1, vld_s2, byp_s1, byp_s2, dth_s1;

  nco_phase u_phase (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .sync_in,
    .xlate_en, .dither_en, .lut_ph, .sync_take
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_s1 <= '0; vld_s1 <= 1'b0; byp_s1 <= 1'b1; dth_s1 <= 1'b0; ph_s1 <= '0;
      x_s2 <= '0; vld_s2 <= 1'b0; byp_s2 <= 1'b1;
    end else begin
      x_s1   <= in_data;
      vld_s1 <= in_valid;
      byp_s1 <= !xlate_en;
      dth_s1 <= dither_en;
      ph_s1  <= lut_ph;
      x_s2   <= x_s1;
      vld_s2 <= vld_s1;
      byp_s2 <= byp_s1;
    end
  end

  nco_sincos u_sincos (
    .clk, .rst_n, .lut_ph(ph_s1), .dither_en(dth_s1), .sin_o(sin_s2), .cos_o(cos_s2)
  );

  nco_mixer u_mixer (
    .clk, .rst_n, .vld_i(vld_s2), .byp_i(byp_s2), .x_i(x_s2),
    .sin_i(sin_s2), .cos_i(cos_s2), .vld_o(out_valid), .i_o(out_i), .q_o(out_q)
  );

  a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, LAT));
  a_r2_bypass_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(xlate_en, LAT)) |-> (out_q == '0 && out_i == $past(in_data, LAT)));
endmodule

// File: tb/test_nco_translator.sv
`timescale 1ns/1ps
module test_nco_translator;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, sync_in = 1'b0, in_valid = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  nco_translator i_nco_translator (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .sync_in,
    .in_valid, .in_data, .out_valid, .out_i, .out_q
  );

  always #2.5 clk = ~clk;

  typedef struct { int ei; int eq; int ui; int uq; int tol; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0, dith_diff = 0;
  string tag = "R1";
  bit done = 0;

  bit [31:0] acc_m = 0, ftw_m = 0;
  bit [23:0] stg_m = 0;
  bit [15:0] ofs_m = 0;
  bit [3:0]  ctl_m = 0;
  bit        arm_m = 0;

  localparam real PI2 = 6.283185307179586;

  function automatic int sin_ref(int p);
    real v;
    v = 32767.0 * $sin(PI2 * (2.0 * real'(p >> 6) + 1.0) / 2048.0);
    if (v >= 0.0) return int'($floor(v + 0.5));
    return -int'($floor(-v + 0.5));
  endfunction

  function automatic int mix_ref(longint prod);
    int r;
    r = int'($floor((real'(prod) + 16384.0) / 32768.0));
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock of stimulus; the bench's own phase model advances with it
  task automatic step(bit v, int x, bit s, bit we, int a, int d);
    bit [15:0] ph;
    bit take;
    item_t it;
    @(negedge clk);
    in_valid = v; in_data = 16'(x); sync_in = s;
    cfg_we = we; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    if (v) begin
      ph = acc_m[31:16] + ofs_m;
      it.tag = tag;
      if (!ctl_m[0]) begin
        it.ei = x; it.eq = 0; it.tol = 0;
      end else begin
        it.ei = mix_ref(longint'(x) * sin_ref(int'(16'(ph + 16'h4000))));
        it.eq = mix_ref(-(longint'(x) * sin_ref(int'(ph))));
        it.tol = ctl_m[1] ? 1 : 0;
      end
      it.ui = it.ei; it.uq = it.eq;
      q.push_back(it);
    end
    take = s && (ctl_m[2] || arm_m);
    acc_m = take ? 32'h0 : acc_m + ftw_m;
    if (we && a == 0) arm_m = d[3];
    else if (take) arm_m = 0;
    if (we) case (a)
      0: ctl_m = 4'(d);
      1: stg_m[7:0] = 8'(d);
      2: stg_m[15:8] = 8'(d);
      3: stg_m[23:16] = 8'(d);
      4: ftw_m = {8'(d), stg_m};
      5: ofs_m[7:0] = 8'(d);
      6: ofs_m[15:8] = 8'(d);
      default: ;
    endcase
  endtask

  task automatic wr(int a, int d); step(0, 0, 0, 1, a, d); endtask
  task automatic smp(int x, bit s = 0); step(1, x, s, 0, 0, 0); endtask
  task automatic set_ftw(bit [31:0] w);
    for (int b = 0; b < 4; b++) wr(1 + b, int'(w[8*b +: 8]));
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      item_t it;
      if (q.size() == 0) begin
        check(0, "R3", "output with no pending sample", 1, 0);
      end else begin
        it = q.pop_front();
        check((out_i - it.ei) <= it.tol && (it.ei - out_i) <= it.tol, it.tag, "I", out_i, it.ei);
        check((out_q - it.eq) <= it.tol && (it.eq - out_q) <= it.tol, it.tag, "Q", out_q, it.eq);
        if (it.tol > 0 && (out_i != it.ui || out_q != it.uq)) dith_diff++;
      end
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid == 0, "R1", "valid in reset", out_valid, 0);
    check(out_i == 0 && out_q == 0, "R1", "data in reset", out_i, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_i == 0 && out_q == 0, "R1", "after reset", out_valid, 0);

    tag = "R2";
    smp(1234); smp(-32768); smp(32767); step(0, 5, 0, 0, 0, 0); smp(-7); smp(0);
    tag = "R3";
    smp(100); step(0, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0); smp(-100);

    tag = "R4";
    wr(0, 1); set_ftw(32'h1000_0000);
    for (int k = 0; k < 20; k++) smp((k % 2) ? -12345 : 20000);
    tag = "R5";
    set_ftw(32'hC000_0000);
    for (int k = 0; k < 8; k++) smp(30000);
    set_ftw(32'h0123_4567);
    for (int k = 0; k < 8; k++) smp(-25000);

    tag = "R6";
    wr(1, 8'h11); wr(2, 8'h22); wr(3, 8'h33);
    for (int k = 0; k < 6; k++) smp(22222);
    wr(4, 8'h04);
    for (int k = 0; k < 6; k++) smp(22222);

    tag = "R7";
    wr(5, 8'h00); wr(6, 8'h20);
    for (int k = 0; k < 4; k++) smp(-32768);
    wr(5, 8'hFF); wr(6, 8'hFF);
    for (int k = 0; k < 4; k++) smp(32767);

    tag = "R8";
    wr(0, 8'h05); wr(5, 8'h00); wr(6, 8'h40);
    for (int k = 0; k < 12; k++) smp(18000, (k == 3 || k == 7 || k == 8));

    tag = "R9";
    wr(0, 8'h09);
    for (int k = 0; k < 6; k++) smp(15000);
    smp(15000, 1);
    for (int k = 0; k < 5; k++) smp(15000);
    smp(15000, 1);
    for (int k = 0; k < 5; k++) smp(15000);
    wr(0, 8'h09);
    for (int k = 0; k < 3; k++) smp(-15000);
    smp(-15000, 1);
    for (int k = 0; k < 4; k++) smp(-15000);

    tag = "R10";
    wr(0, 8'h01);
    for (int k = 0; k < 10; k++) smp(26000, (k % 3) == 1);

    tag = "R11";
    wr(0, 8'h03); set_ftw(32'h0765_4321);
    for (int k = 0; k < 40; k++) smp(30000);
    wr(0, 8'h01);

    tag = "R2";
    wr(0, 8'h00);
    smp(-4321); smp(4321);

    repeat (10) step(0, 0, 0, 0, 0, 0);
    check(q.size() == 0, "R3", "samples still pending", q.size(), 0);
    check(dith_diff > 0, "R11", "dithered outputs differing", dith_diff, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule